// File: doc/BRIEF.md
# Trap Base Register and Vector Generator

This block keeps the processor's trap base register and works out where instruction fetch goes when a trap is taken. The register is 32 bits wide. Its upper part is a table base that supervisor software sets. It must be a multiple of 4096. The middle byte is the trap type, and only the trap hardware writes it. The four lowest bits always read as zero.

A trap can come from three kinds of source:
- one or more synchronous exception causes,
- a software trap instruction with its number,
- a pending external interrupt level.

A fixed priority picks one source, and the block encodes it as an 8-bit trap type. One cycle after the trap is accepted, the block presents a handler address and a valid pulse. The address is the base plus sixteen times the type, which gives each of the 256 handler slots 16 bytes.

Register reads and writes go through a privileged access port. A read or write attempted in user mode leaves the register unchanged. It raises a privileged-instruction trap of its own.

Top module: `trap_vec_unit`

## Requirements
- R1: After reset the register reads 0x00000000 and `vec_valid_o` is low.
- R2: A supervisor write stores `csr_wdata_i[31:12]` as the base. Bits 11:0 of the written data are ignored. Reads return {base, trap type, 4'b0000}.
- R3: A trap is accepted on a rising edge where a trap is requested and a cause is pending. In the next cycle `vec_valid_o` is high for one cycle, the register's bits 11:4 and `trap_type_o` hold the chosen type, and `vec_addr_o` equals base + 16 × type. The base used is the value held before any write in the same cycle.
- R4: Exception input bit k maps to the type at position k of this list: 0x01, 0x02, 0x04, 0x05, 0x06, 0x07, 0x0A, 0x2A. The bits mean, in order: instruction access fault, illegal instruction, floating point disabled, window overflow, window underflow, misaligned address, tag overflow, divide by zero.
- R5: Priority is fixed. Synchronous codes win first, lowest code first, with the privileged fault 0x03 placed between 0x02 and 0x04. Software traps come next, and the interrupt level comes last.
- R6: A software trap with number n gives type 0x80 + n[6:0], so the type always lies in 0x80..0xFF.
- R7: An interrupt level L from 1 to 15 gives type 0x10 + L. Level 0 means no request.
- R8: A read or write with `supervisor_i` low leaves the register unchanged. The block then takes a trap even when `trap_take_i` is low. The type is 0x03 unless exception bit 0 or bit 1 is also set, in which case that code wins.
- R9: With no trap request and no user-mode access, `vec_valid_o` stays low and the trap type stays unchanged. The same holds when `trap_take_i` is high but no cause is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| supervisor_i | input | 1 | Processor is in supervisor mode |
| csr_wr_i | input | 1 | Register write request |
| csr_rd_i | input | 1 | Register read request |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Register contents |
| exc_i | input | 8 | Synchronous exception causes (bit mapping in R4) |
| swtrap_i | input | 1 | Software trap instruction executing |
| swtrap_num_i | input | 7 | Software trap number |
| irq_level_i | input | 4 | Pending interrupt level, 0 = none |
| trap_take_i | input | 1 | Take the highest-priority pending trap |
| vec_valid_o | output | 1 | Handler address valid (one-cycle pulse) |
| vec_addr_o | output | 32 | Handler fetch address |
| trap_type_o | output | 8 | Current trap type field |

## Verification
The main encode-and-vector path is driven several ways:
- Single directed causes pin each exception code, the software offset and the interrupt mapping.
- Two known vectors check the base + 16 × type arithmetic: a software trap 5 with a zero base must land on 0x850, and the same trap with base 0x12345000 must land on 0x12345850.
- Random mixes with several causes set at once separate a correct priority order from a wrong one.
- Interleaved user-mode accesses show whether the privileged fault both blocks the write and outranks software traps.
- Cycles with a trap request but no pending cause show that nothing is taken spuriously.

// File: rtl/trap_vec_pkg.sv
package trap_vec_pkg;
  localparam int NUM_EXC  = 8;
  localparam int NUM_SYNC = NUM_EXC + 1;
  localparam int PRIV_SLOT = 2;  // privileged fault sits between codes 0x02 and 0x04

  localparam logic [7:0] SYNC_CODE [NUM_SYNC] =
    '{8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06, 8'h07, 8'h0A, 8'h2A};

  localparam logic [7:0] TT_SOFT_BASE = 8'h80;
  localparam logic [7:0] TT_IRQ_BASE  = 8'h10;

  typedef enum logic [1:0] {SRC_NONE, SRC_SYNC, SRC_SOFT, SRC_IRQ} trap_src_e;
endpackage

// File: rtl/tv_cause_sel.sv
module tv_cause_sel
  import trap_vec_pkg::*;
#(
  parameter int TT_W  = 8,
  parameter int SW_W  = 7,
  parameter int IRQ_W = 4
) (
  input  logic [NUM_EXC-1:0] exc_i,
  input  logic               priv_fault_i,
  input  logic               swtrap_i,
  input  logic [SW_W-1:0]    swtrap_num_i,
  input  logic [IRQ_W-1:0]   irq_level_i,
  output logic               req_o,
  output trap_src_e          src_o,
  output logic [TT_W-1:0]    type_o
);
  logic [NUM_SYNC-1:0] sync;
  logic [NUM_SYNC-1:0] grant;
  logic                sync_any;
  logic [TT_W-1:0]     sync_type;

  // merge the privileged fault into the ascending code order
  generate
    for (genvar k = 0; k < NUM_EXC; k++) begin : g_map
      if (k < PRIV_SLOT) begin : g_lo
        assign sync[k] = exc_i[k];
      end else begin : g_hi
        assign sync[k+1] = exc_i[k];
      end
    end
  endgenerate
  assign sync[PRIV_SLOT] = priv_fault_i;

  always_comb begin
    grant     = '0;
    sync_type = '0;
    for (int i = NUM_SYNC - 1; i >= 0; i--) begin
      if (sync[i]) begin
        grant     = '0;
        grant[i]  = 1'b1;
        sync_type = TT_W'(SYNC_CODE[i]);
      end
    end
  end

  assign sync_any = |sync;

  always_comb begin
    if (sync_any) begin
      src_o  = SRC_SYNC;
      type_o = sync_type;
    end else if (swtrap_i) begin
      src_o  = SRC_SOFT;
      type_o = TT_W'(TT_SOFT_BASE) | TT_W'(swtrap_num_i);
    end else if (irq_level_i != '0) begin
      src_o  = SRC_IRQ;
      type_o = TT_W'(TT_IRQ_BASE) + TT_W'(irq_level_i);
    end else begin
      src_o  = SRC_NONE;
      type_o = '0;
    end
  end

  assign req_o = (src_o != SRC_NONE);
endmodule

// File: rtl/tv_base_reg.sv
module tv_base_reg #(
  parameter int XLEN     = 32,
  parameter int BASE_LSB = 12,
  parameter int TT_W     = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     base_we_i,
  input  logic [XLEN-1:BASE_LSB]   base_wdata_i,
  input  logic                     tt_we_i,
  input  logic [TT_W-1:0]          tt_i,
  output logic [XLEN-1:BASE_LSB]   base_o,
  output logic [TT_W-1:0]          tt_o
);
  logic [XLEN-1:BASE_LSB] base_q;
  logic [TT_W-1:0]        tt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      tt_q   <= '0;
    end else begin
      if (base_we_i) base_q <= base_wdata_i;
      if (tt_we_i)   tt_q   <= tt_i;
    end
  end

  assign base_o = base_q;
  assign tt_o   = tt_q;
endmodule

// File: rtl/trap_vec_unit.sv
module trap_vec_unit
  import trap_vec_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int BASE_LSB = 12,
  parameter int TT_W     = 8,
  parameter int SW_W     = 7,
  parameter int IRQ_W    = 4
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               supervisor_i,
  input  logic               csr_wr_i,
  input  logic               csr_rd_i,
  input  logic [XLEN-1:0]    csr_wdata_i,
  output logic [XLEN-1:0]    csr_rdata_o,
  input  logic [NUM_EXC-1:0] exc_i,
  input  logic               swtrap_i,
  input  logic [SW_W-1:0]    swtrap_num_i,
  input  logic [IRQ_W-1:0]   irq_level_i,
  input  logic               trap_take_i,
  output logic               vec_valid_o,
  output logic [XLEN-1:0]    vec_addr_o,
  output logic [TT_W-1:0]    trap_type_o
);
  localparam int TT_LSB = BASE_LSB - TT_W;

  logic                   priv_fault, take, req, accept, base_we;
  trap_src_e              src;
  logic [TT_W-1:0]        sel_type, tt_q;
  logic [XLEN-1:BASE_LSB] base_q;
  logic [XLEN-1:0]        vec_d, vec_q;
  logic                   valid_q;

  assign priv_fault = (csr_wr_i | csr_rd_i) & ~supervisor_i;
  assign take       = trap_take_i | priv_fault;
  assign accept     = take & req;
  assign base_we    = csr_wr_i & supervisor_i;

  tv_cause_sel #(.TT_W(TT_W), .SW_W(SW_W), .IRQ_W(IRQ_W)) u_sel (
    .exc_i        (exc_i),
    .priv_fault_i (priv_fault),
    .swtrap_i     (swtrap_i),
    .swtrap_num_i (swtrap_num_i),
    .irq_level_i  (irq_level_i),
    .req_o        (req),
    .src_o        (src),
    .type_o       (sel_type)
  );

  tv_base_reg #(.XLEN(XLEN), .BASE_LSB(BASE_LSB), .TT_W(TT_W)) u_reg (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .base_we_i    (base_we),
    .base_wdata_i (csr_wdata_i[XLEN-1:BASE_LSB]),
    .tt_we_i      (accept),
    .tt_i         (sel_type),
    .base_o       (base_q),
    .tt_o         (tt_q)
  );

  // base is aligned, so concatenation equals base + type*16
  assign vec_d = {base_q, sel_type, {TT_LSB{1'b0}}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
    end else begin
      valid_q <= accept;
      if (accept) vec_q <= vec_d;
    end
  end

  assign vec_valid_o = valid_q;
  assign vec_addr_o  = vec_q;
  assign trap_type_o = tt_q;
  assign csr_rdata_o = {base_q, tt_q, {TT_LSB{1'b0}}};

  assert_take_valid_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_take_i && (exc_i != '0 || swtrap_i || irq_level_i != '0)) |=> vec_valid_o);

  assert_vec_type_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vec_valid_o |-> (vec_addr_o[BASE_LSB-1:TT_LSB] == trap_type_o &&
                     vec_addr_o[XLEN-1:BASE_LSB] == $past(base_q)));

  assert_user_no_write_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    priv_fault |=> $stable(csr_rdata_o[XLEN-1:BASE_LSB]));

  assert_priv_type_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (priv_fault && exc_i[1:0] == 2'b00) |=> (vec_valid_o && trap_type_o == TT_W'(8'h03)));

  assert_soft_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_take_i && swtrap_i && !priv_fault && exc_i == '0) |=> trap_type_o[TT_W-1]);

  assert_irq_type_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_take_i && !priv_fault && exc_i == '0 && !swtrap_i && irq_level_i != '0)
    |=> trap_type_o == TT_W'(TT_IRQ_BASE) + TT_W'($past(irq_level_i)));

  assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_take_i && !priv_fault) |=> (!vec_valid_o && $stable(trap_type_o)));

  assert_src_sync_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exc_i != '0 || priv_fault) |-> src == SRC_SYNC);
endmodule

// File: tb/trap_vec_unit_test.sv
`timescale 1ns/1ps
module trap_vec_unit_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sup, wr, rd, sw, take;
  logic [31:0] wdata;
  logic [7:0]  exc;
  logic [6:0]  num;
  logic [3:0]  irq;
  logic [31:0] rdata, vaddr;
  logic        vvalid;
  logic [7:0]  ttype;

  int checks = 0;
  int errors = 0;
  logic [19:0] base_m = '0;
  logic [7:0]  tt_m   = '0;

  always #5 clk = ~clk;

  trap_vec_unit uut (
    .clk_i(clk), .rst_ni(rst_n), .supervisor_i(sup), .csr_wr_i(wr), .csr_rd_i(rd),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .exc_i(exc), .swtrap_i(sw),
    .swtrap_num_i(num), .irq_level_i(irq), .trap_take_i(take),
    .vec_valid_o(vvalid), .vec_addr_o(vaddr), .trap_type_o(ttype)
  );

  function automatic logic [7:0] exc_code(int k);
    case (k)
      0: return 8'h01;  1: return 8'h02;  2: return 8'h04;  3: return 8'h05;
      4: return 8'h06;  5: return 8'h07;  6: return 8'h0A;  default: return 8'h2A;
    endcase
  endfunction

  // returns {request, type}
  function automatic logic [8:0] pick(logic [7:0] e, logic pf, logic s,
                                      logic [6:0] n, logic [3:0] l);
    logic [7:0] best = 8'hFF;
    logic       hit  = 1'b0;
    for (int k = 0; k < 8; k++)
      if (e[k] && exc_code(k) < best) begin best = exc_code(k); hit = 1'b1; end
    if (pf && 8'h03 < best) begin best = 8'h03; hit = 1'b1; end
    if (hit) return {1'b1, best};
    if (s) return {1'b1, 8'h80 + {1'b0, n}};
    if (l != 0) return {1'b1, 8'h10 + {4'h0, l}};
    return 9'h000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    sup = 1'b1; wr = 1'b0; rd = 1'b0; sw = 1'b0; take = 1'b0;
    wdata = '0; exc = '0; num = '0; irq = '0;
  endtask

  // inputs already driven at a negedge: predict, clock, compare
  task automatic step(string req);
    logic       pf   = (wr | rd) & ~sup;
    logic [8:0] p    = pick(exc, pf, sw, num, irq);
    logic       ev   = (take | pf) & p[8];
    logic [31:0] ea  = {base_m, 12'h000} + 32'(p[7:0]) * 32'd16;
    if (ev) tt_m = p[7:0];
    if (wr && sup) base_m = wdata[31:12];
    @(posedge clk);
    @(negedge clk);
    chk({req, " valid"}, {31'd0, vvalid}, {31'd0, ev});
    if (ev) chk({req, " vector"}, vaddr, ea);
    chk({req, " reg"}, rdata, {base_m, tt_m, 4'h0});
    chk({req, " type"}, {24'd0, ttype}, {24'd0, tt_m});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 reg", rdata, 32'h0);
    chk("R1 valid", {31'd0, vvalid}, 32'd0);

    // R6 software trap 5 with zero base
    sw = 1'b1; num = 7'd5; take = 1'b1;
    step("R6 soft5 zero base");
    chk("R6 vector 0x850", vaddr, 32'h0000_0850);
    idle();
    // R2 supervisor write, low bits ignored
    wr = 1'b1; wdata = 32'h1234_5FFF;
    step("R2 write");
    chk("R2 readback", rdata, 32'h1234_5850);
    idle();
    sw = 1'b1; num = 7'd5; take = 1'b1;
    step("R3 soft5");
    chk("R3 vector", vaddr, 32'h1234_5850);
    idle();
    // R7 top interrupt level
    irq = 4'hF; take = 1'b1;
    step("R7 irq15");
    chk("R7 type", {24'd0, ttype}, 32'h1F);
    idle();
    irq = 4'h0; take = 1'b1;
    step("R9 no cause");
    idle();
    // R8 user write blocked, traps without take
    sup = 1'b0; wr = 1'b1; wdata = 32'hFFFF_F000; sw = 1'b1;
    step("R8 user write");
    chk("R8 type", {24'd0, ttype}, 32'h03);
    idle();
    sup = 1'b0; rd = 1'b1; exc = 8'h02;
    step("R8 user read loses to 0x02");
    idle();
    // R4 each exception alone
    for (int k = 0; k < 8; k++) begin
      exc = 8'(1 << k); take = 1'b1;
      step("R4 single exc");
    end
    // R5 mixture: 0x05 beats 0x2A, software, irq
    exc = 8'h88; sw = 1'b1; irq = 4'h3; take = 1'b1;
    step("R5 mixed");
    chk("R5 type", {24'd0, ttype}, 32'h05);
    idle();
    // R9 quiet cycles
    exc = 8'hFF; sw = 1'b1; irq = 4'h9;
    step("R9 no take");
    idle();

    for (int i = 0; i < 4000; i++) begin
      exc   = (($urandom % 3) == 0) ? 8'($urandom & $urandom & $urandom) : 8'h00;
      sw    = (($urandom % 4) == 0);
      num   = 7'($urandom);
      irq   = (($urandom % 3) == 0) ? 4'($urandom) : 4'h0;
      take  = (($urandom % 2) == 0);
      wr    = (($urandom % 6) == 0);
      rd    = (($urandom % 8) == 0);
      sup   = (($urandom % 4) != 0);
      wdata = $urandom;
      step("R3 R5 random");
    end
    idle();
    step("R9 final idle");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule